// File: doc/BRIEF.md
# Serial Command and Segment-RAM Receiver

This block is the host-facing front end of a 4-common, 50-column segment display controller. A host drives an active-low select, a serial clock and a serial data line. The block samples these lines into its own system clock domain through two-flop synchronisers and assembles bytes most significant bit first. Each byte is either a command or display data.

Commands are decoded into configuration fields for the scan and bias logic: display enable, drive waveform, power mode, bias, oscillator source, frame-rate code, blink code and all-pixel forcing. Bit 7 of each command byte chooses what comes next. A 1 means another command follows. A 0 means the bytes that follow are display data, and they stay data until the select is released. Display data is written four bits at a time into a 50 x 4 column memory. The memory address steps up by one per nibble and wraps back to column 0. The display scan logic reads the memory through a combinational read port.

Top module: `segcmd_rx`

## Requirements
- R1: After the asynchronous reset these are the outputs: dispOn=0, frameInv=0, pwrMode=2'b10, biasHalf=0, extClk=0, frameRate=0, blinkRate=0, allOn=0 and allOff=0.
- R2: Bits are captured on rising serial clock edges while csN is low, MSB first. csN high clears the bit count, so a partial byte is discarded and the next byte starts fresh.
- R3: A command byte whose bit 7 is 1 keeps the receiver in command mode. When bit 7 is 0, every following byte is display data, even if its bit 7 is 1, until csN goes high. csN high returns the receiver to command mode.
- R4: A command with bits 6:4 = 100 loads three fields: dispOn from bit 3, frameInv from bit 2 and pwrMode from bits 1:0.
- R5: A command with bits 6:4 = 101 loads three fields: biasHalf from bit 3, extClk from bit 2 and frameRate from bits 1:0.
- R6: A command with bits 6:3 = 1110 loads blinkRate from bits 1:0. A command with bits 6:2 = 11111 loads allOn from bit 1 and allOff from bit 0. Any other pattern in bits 6:4 = 110 or 111, apart from the reset code, changes no output.
- R7: A command with bit 6 = 0 loads the write address from bits 5:0. A value above 49 loads 0.
- R8: In a data byte, the upper nibble goes to the current column and the lower nibble to the column after it. For each nibble, bit 3 lands in rdData[0] (COM0), bit 2 in rdData[1], bit 1 in rdData[2] and bit 0 in rdData[3].
- R9: The write address rises by one after each nibble written. After column 49 it wraps to 0.
- R10: A nibble is not written if csN rises before all four of its bits have arrived, and the address does not move.
- R11: The command with bits 6:0 = 1101010 returns every configuration output to its R1 value and sets the write address to 0. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from host |
| sdata | input | 1 | Serial data from host |
| rdAddr | input | 6 | Scan read column |
| rdData | output | 4 | Column bits, bit k drives COMk |
| dispOn | output | 1 | Display enable |
| frameInv | output | 1 | 1 selects frame inversion, 0 line inversion |
| pwrMode | output | 2 | Power mode code |
| biasHalf | output | 1 | 1 selects half bias, 0 third bias |
| extClk | output | 1 | 1 selects external clock |
| frameRate | output | 2 | Frame rate code |
| blinkRate | output | 2 | Blink rate code, 0 is off |
| allOn | output | 1 | Force all pixels on |
| allOff | output | 1 | Force all pixels off |

## Verification
A serial clock edge needs two synchroniser flops and one edge-detect flop before the block sees it. A register or memory column therefore changes on the third system clock edge after the serial clock rise that completes a command byte or a nibble. The bench holds each serial level for four system clocks and waits several more after each transfer. It samples outputs on the falling system clock edge well after that third edge. The memory is read combinationally, so read checks look one time unit after rdAddr is set.

// File: rtl/segrx_pkg.sv
package segrx_pkg;
  localparam int NUM_COLS = 50;
  localparam int COM_W = 4;
  localparam int ADDR_W = $clog2(NUM_COLS);
  localparam logic [1:0] PWR_DEFAULT = 2'b10;
  localparam logic [6:0] SWRST_CODE = 7'b1101010;

  typedef struct packed {
    logic             cmdStb;
    logic             nibStb;
    logic [6:0]       cmdBits;
    logic [COM_W-1:0] nib;
  } rxStb_t;
endpackage

// File: rtl/segrx_ctrl.sv
module segrx_ctrl
  import segrx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   sclk,
  input  logic   sdata,
  output rxStb_t stb
);
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] MID_BIT = CNT_W'(COM_W - 1);

  logic csMeta, csSync;
  logic clkMeta, clkSync, clkDly;
  logic datMeta, datSync;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic dataMode;
  logic sclkRise;
  logic [BYTE_W-1:0] nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csMeta <= 1'b1; csSync <= 1'b1;
      clkMeta <= 1'b0; clkSync <= 1'b0; clkDly <= 1'b0;
      datMeta <= 1'b0; datSync <= 1'b0;
    end else begin
      csMeta <= csN; csSync <= csMeta;
      clkMeta <= sclk; clkSync <= clkMeta; clkDly <= clkSync;
      datMeta <= sdata; datSync <= datMeta;
    end
  end

  assign sclkRise = clkSync & ~clkDly & ~csSync;
  assign nextByte = {shiftReg[BYTE_W-2:0], datSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shiftReg <= '0;
      dataMode <= 1'b0;
    end else if (csSync) begin
      bitCnt <= '0;
      dataMode <= 1'b0;
    end else if (sclkRise) begin
      shiftReg <= nextByte;
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT && !dataMode) dataMode <= ~nextByte[BYTE_W-1];
    end
  end

  always_comb begin
    stb.cmdStb = sclkRise && (bitCnt == LAST_BIT) && !dataMode;
    stb.nibStb = sclkRise && dataMode && (bitCnt == LAST_BIT || bitCnt == MID_BIT);
    stb.cmdBits = nextByte[6:0];
    stb.nib = nextByte[COM_W-1:0];
  end

  // R2
  csclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> (bitCnt == '0 && !dataMode));

  // R3
  datamode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmdStb && !nextByte[BYTE_W-1]) |=> dataMode);
endmodule

// File: rtl/segrx_dpath.sv
module segrx_dpath
  import segrx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStb_t            stb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [COM_W-1:0]  rdData,
  output logic              dispOn,
  output logic              frameInv,
  output logic [1:0]        pwrMode,
  output logic              biasHalf,
  output logic              extClk,
  output logic [1:0]        frameRate,
  output logic [1:0]        blinkRate,
  output logic              allOn,
  output logic              allOff
);
  localparam logic [ADDR_W-1:0] LAST_COL = ADDR_W'(NUM_COLS - 1);

  logic [ADDR_W-1:0] addrPtr;
  logic [COM_W-1:0] mem [NUM_COLS];
  logic [COM_W-1:0] wrWord;
  logic isSwrst, isAddr, isMode, isDisp, isBlink, isAllPix;

  for (genvar k = 0; k < COM_W; k++) begin : g_nibmap
    assign wrWord[k] = stb.nib[COM_W-1-k];
  end

  assign isSwrst  = stb.cmdStb && stb.cmdBits == SWRST_CODE;
  assign isAddr   = stb.cmdStb && !stb.cmdBits[6];
  assign isMode   = stb.cmdStb && stb.cmdBits[6:4] == 3'b100;
  assign isDisp   = stb.cmdStb && stb.cmdBits[6:4] == 3'b101;
  assign isBlink  = stb.cmdStb && stb.cmdBits[6:3] == 4'b1110;
  assign isAllPix = stb.cmdStb && stb.cmdBits[6:2] == 5'b11111;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPtr <= '0;
      dispOn <= 1'b0; frameInv <= 1'b0; pwrMode <= PWR_DEFAULT;
      biasHalf <= 1'b0; extClk <= 1'b0; frameRate <= '0;
      blinkRate <= '0; allOn <= 1'b0; allOff <= 1'b0;
    end else if (isSwrst) begin
      addrPtr <= '0;
      dispOn <= 1'b0; frameInv <= 1'b0; pwrMode <= PWR_DEFAULT;
      biasHalf <= 1'b0; extClk <= 1'b0; frameRate <= '0;
      blinkRate <= '0; allOn <= 1'b0; allOff <= 1'b0;
    end else begin
      if (isAddr)
        addrPtr <= (stb.cmdBits[5:0] > LAST_COL) ? '0 : stb.cmdBits[ADDR_W-1:0];
      if (isMode) begin
        dispOn <= stb.cmdBits[3]; frameInv <= stb.cmdBits[2]; pwrMode <= stb.cmdBits[1:0];
      end
      if (isDisp) begin
        biasHalf <= stb.cmdBits[3]; extClk <= stb.cmdBits[2]; frameRate <= stb.cmdBits[1:0];
      end
      if (isBlink) blinkRate <= stb.cmdBits[1:0];
      if (isAllPix) begin
        allOn <= stb.cmdBits[1]; allOff <= stb.cmdBits[0];
      end
      if (stb.nibStb) addrPtr <= (addrPtr == LAST_COL) ? '0 : addrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.nibStb) mem[addrPtr] <= wrWord;
  end

  assign rdData = (rdAddr > LAST_COL) ? '0 : mem[rdAddr];

  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrPtr <= LAST_COL);

  // R7
  addr_oor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isAddr && stb.cmdBits[5:0] > LAST_COL) |=> addrPtr == '0);

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.nibStb && addrPtr == LAST_COL) |=> addrPtr == '0);

  // R8
  memwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.nibStb |=> mem[$past(addrPtr)] == {$past(stb.nib[0]), $past(stb.nib[1]),
                                             $past(stb.nib[2]), $past(stb.nib[3])});

  // R11
  swrst_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSwrst |=> (!dispOn && addrPtr == '0 && pwrMode == PWR_DEFAULT));
endmodule

// File: rtl/segcmd_rx.sv
module segcmd_rx
  import segrx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [COM_W-1:0]  rdData,
  output logic              dispOn,
  output logic              frameInv,
  output logic [1:0]        pwrMode,
  output logic              biasHalf,
  output logic              extClk,
  output logic [1:0]        frameRate,
  output logic [1:0]        blinkRate,
  output logic              allOn,
  output logic              allOff
);
  rxStb_t stb;

  segrx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdata(sdata), .stb(stb)
  );

  segrx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .rdData(rdData),
    .dispOn(dispOn), .frameInv(frameInv), .pwrMode(pwrMode),
    .biasHalf(biasHalf), .extClk(extClk), .frameRate(frameRate),
    .blinkRate(blinkRate), .allOn(allOn), .allOff(allOff)
  );
endmodule

// File: tb/segcmd_rx_test.sv
module segcmd_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [5:0] rdAddr = '0;
  logic [3:0] rdData;
  logic dispOn, frameInv, biasHalf, extClk, allOn, allOff;
  logic [1:0] pwrMode, frameRate, blinkRate;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segcmd_rx uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdata(sdata),
    .rdAddr(rdAddr), .rdData(rdData), .dispOn(dispOn), .frameInv(frameInv),
    .pwrMode(pwrMode), .biasHalf(biasHalf), .extClk(extClk),
    .frameRate(frameRate), .blinkRate(blinkRate), .allOn(allOn), .allOff(allOff)
  );

  function automatic logic [3:0] revNib(input logic [3:0] n);
    return {n[0], n[1], n[2], n[3]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      sdata = b[i];
      idle(HOLD);
      sclk = 1'b1;
      idle(HOLD);
      sclk = 1'b0;
    end
  endtask

  task automatic selectOn();
    csN = 1'b0; idle(HOLD);
  endtask

  task automatic selectOff();
    idle(HOLD); csN = 1'b1; idle(2 * HOLD);
  endtask

  task automatic checkCol(input string req, input int col, input logic [3:0] exp);
    rdAddr = 6'(col);
    #1;
    check(req, rdData, exp);
  endtask

  task automatic checkCfg(input string req, input logic [12:0] exp);
    check(req, {dispOn, frameInv, pwrMode, biasHalf, extClk, frameRate,
                blinkRate, allOn, allOff}, exp);
  endtask

  task automatic testReset();
    checkCfg("R1 defaults", {1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0});
  endtask

  task automatic testModeDisp();
    selectOn();
    sendBits(8'hCD, 8);
    selectOff();
    check("R4 mode set", {dispOn, frameInv, pwrMode}, 4'b1101);
    selectOn();
    sendBits(8'hDB, 8);
    idle(HOLD);
    check("R5 display ctl first", {biasHalf, extClk, frameRate}, 4'b1011);
    sendBits(8'hD6, 8);
    selectOff();
    check("R3 chained command", {biasHalf, extClk, frameRate}, 4'b0110);
  endtask

  task automatic testBlinkPix();
    selectOn();
    sendBits(8'hF2, 8);
    sendBits(8'hFE, 8);
    selectOff();
    check("R6 blink", blinkRate, 2);
    check("R6 all pixel", {allOn, allOff}, 2'b10);
    selectOn();
    sendBits(8'hEF, 8);
    sendBits(8'hFB, 8);
    selectOff();
    checkCfg("R6 unrecognised ignored",
             {1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 2'b10, 2'b10, 1'b1, 1'b0});
  endtask

  task automatic testDataWrite();
    selectOn();
    sendBits(8'h05, 8);
    sendBits(8'hA5, 8);
    sendBits(8'h3C, 8);
    selectOff();
    checkCol("R8 upper nibble", 5, revNib(4'hA));
    checkCol("R3 data byte with bit7 set", 6, revNib(4'h5));
    checkCol("R9 increment", 7, revNib(4'h3));
    checkCol("R9 increment", 8, revNib(4'hC));
    check("R3 data not decoded", {dispOn, frameInv, pwrMode}, 4'b1101);
  endtask

  task automatic testWrap();
    selectOn();
    sendBits(8'h31, 8);
    sendBits(8'h9E, 8);
    selectOff();
    checkCol("R9 last column", 49, revNib(4'h9));
    checkCol("R9 wrap to zero", 0, revNib(4'hE));
  endtask

  task automatic testOutOfRange();
    selectOn();
    sendBits(8'hBF, 8);
    sendBits(8'h4D, 8);
    sendBits(8'h6F, 8);
    selectOff();
    checkCol("R7 oor address loads 0", 0, revNib(4'h6));
    checkCol("R7 next column", 1, revNib(4'hF));
  endtask

  task automatic testPartial();
    selectOn();
    sendBits(8'h03, 8);
    sendBits(8'hF0, 8);
    selectOff();
    checkCol("R8 preload", 3, 4'hF);
    selectOn();
    sendBits(8'h03, 8);
    sendBits(8'hA0, 3);
    selectOff();
    checkCol("R10 three bits not written", 3, 4'hF);
    selectOn();
    sendBits(8'h03, 8);
    sendBits(8'h54, 6);
    selectOff();
    checkCol("R2 fresh byte after partial", 3, revNib(4'h5));
    checkCol("R10 partial second nibble dropped", 4, 4'h0);
  endtask

  task automatic testSoftReset();
    selectOn();
    sendBits(8'hEA, 8);
    selectOff();
    checkCfg("R11 soft reset defaults", {1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0});
    selectOn();
    sendBits(8'h40, 8);
    sendBits(8'h21, 8);
    selectOff();
    checkCol("R11 address cleared", 0, revNib(4'h2));
    checkCol("R11 address cleared next", 1, revNib(4'h1));
    checkCol("R11 memory kept", 5, revNib(4'hA));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    testReset();
    testModeDisp();
    testBlinkPix();
    testDataWrite();
    testWrap();
    testOutOfRange();
    testPartial();
    testSoftReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule